// File: doc/BRIEF.md
# Streaming GHASH Accumulator

This block folds a byte stream of any length into a 128-bit GHASH digest under a 128-bit hash subkey H. Bytes arrive one per accepted cycle and are packed into 16-byte blocks. When a block is complete, it is XORed into the running digest, and the digest is then multiplied by H in GF(2^128). The multiplier is bit-serial and takes one bit of the operand per cycle. A message ends in one of two ways: the last byte is marked, or a separate flush request arrives. At the end, any partial block is zero-padded and absorbed once. The finished digest is then presented together with a one-cycle done strobe.

Loading a subkey also produces a pre-shifted copy of H, which is H multiplied by x in the doubling form used by carry-less multiply datapaths. A load is accepted only when the stated key length is 16 bytes. A valid load also starts a new message: it clears the digest and the byte buffer.

A small state machine has three states, `ST_IDLE`, `ST_MULT` and `ST_DONE`, and these transitions:
- `ST_IDLE`→`ST_MULT` when a block is dispatched to the multiplier.
- `ST_IDLE`→`ST_DONE` on a flush with an empty buffer.
- `ST_MULT`→`ST_IDLE` when a non-final multiply completes.
- `ST_MULT`→`ST_DONE` when the final multiply completes.
- `ST_DONE`→`ST_IDLE` always, after one cycle.

Top module: `ghash_stream`

## Requirements
- R1: After reset, `digest_out` is zero, `done` is low and `in_ready` is high.
- R2: A load with `key_len` = 16 stores H and sets `hkey_x` one cycle later, with `key_err` low. The value of `hkey_x` is formed as follows:
  - Rotate H, taken as a 128-bit big-endian value, left by one bit.
  - If bit 127 of H was 1, XOR bits 127:120 of the result with 0xC2.
- R3: A load with any other `key_len` pulses `key_err` high for one cycle and leaves H and `hkey_x` unchanged.
- R4: Byte i of a block (0 to 15, counted from the block start) occupies bits 127-8i down to 120-8i. The message {0x80} therefore yields a digest equal to H.
- R5: Every completed block updates the digest as D ← (D XOR block)·H. The product uses the bit-reflected GF(2^128) convention, where bit 127 is the x^0 coefficient and the reduction constant is 0xE1 followed by 120 zero bits.
- R6: A trailing partial block is zero-padded to 16 bytes and absorbed once. This is the same whether the message ends with `in_last` or with `flush`.
- R7: When the buffer is empty at the end of a message, no extra block is absorbed. The empty message gives a zero digest.
- R8: `done` is high for exactly one cycle, and `digest_out` changes only in that cycle. The next message starts from a zero digest.
- R9: `in_ready` is low while a multiply is in progress. Bytes, `in_last` and `flush` presented while `in_ready` is low have no effect.
- R10: An accepted key load discards any buffered bytes and the digest accumulated so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_load | input | 1 | Key load request, taken when `in_ready` is high |
| key_len | input | 5 | Key length in bytes |
| key_in | input | 128 | Hash subkey H, big-endian |
| key_err | output | 1 | One-cycle pulse on a rejected key load |
| hkey_x | output | 128 | H multiplied by x (pre-shifted subkey) |
| in_valid | input | 1 | A byte is presented |
| in_byte | input | 8 | Data byte |
| in_last | input | 1 | The presented byte ends the message |
| flush | input | 1 | End the message without a byte (ignored while `in_valid` is high) |
| in_ready | output | 1 | Byte, flush and key load are accepted |
| digest_out | output | 128 | Final digest, big-endian, high word first |
| done | output | 1 | One-cycle strobe: `digest_out` holds a new result |

## Verification
The hardest cases to reach are the ones where inputs arrive while the multiplier is busy: garbage bytes and spurious `in_last` flags must be dropped during that time. The stimulus drives such garbage on every cycle that `in_ready` is low, on a random subset of messages.

The other hard-to-reach endings are a flush on an empty buffer and a flush right after exactly a full block. The bench sends the same messages both with `in_last` and with `flush`, and expects identical digests. Random lengths from 0 to 48 bytes cover every fill level at the end of a message.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
    localparam int GH_BYTES = 16;
    localparam int GH_W     = GH_BYTES * 8;
    localparam int GH_IDXW  = $clog2(GH_BYTES);
    localparam int GH_CNTW  = $clog2(GH_W);
    localparam int GH_LENW  = GH_IDXW + 1;
    localparam logic [GH_W-1:0] GH_RED  = {8'hE1, {(GH_W-8){1'b0}}};
    localparam logic [63:0]     GH_FOLD = 64'hC200_0000_0000_0000;

    typedef enum logic [1:0] {ST_IDLE, ST_MULT, ST_DONE} gh_state_e;

    // Doubling of the subkey: halves shifted with cross carry, folded when bit 127 was set.
    function automatic logic [127:0] derive_hx(input logic [127:0] h);
        logic [63:0] hi, lo, nhi, nlo;
        hi  = h[127:64];
        lo  = h[63:0];
        nlo = {lo[62:0], hi[63]};
        nhi = {hi[62:0], lo[63]};
        if (hi[63]) nhi = nhi ^ GH_FOLD;
        return {nhi, nlo};
    endfunction
endpackage

// File: rtl/ghash_byte_packer.sv
module ghash_byte_packer
    import ghash_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [7:0]         byte_in,
    input  logic               clear,
    output logic [GH_IDXW-1:0] fill,
    output logic [GH_W-1:0]    blk_view
);
    logic [GH_W-1:0]    buf_q;
    logic [GH_IDXW-1:0] fill_q;
    logic [GH_CNTW-1:0] lsb;

    // Byte 0 of a block lands in the top byte lane.
    always_comb begin
        lsb      = GH_CNTW'(GH_W - 8) - {fill_q, 3'b000};
        blk_view = buf_q;
        if (push) blk_view[lsb +: 8] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            buf_q  <= '0;
            fill_q <= '0;
        end else if (push) begin
            buf_q  <= blk_view;
            fill_q <= fill_q + 1'b1;
        end
    end

    assign fill = fill_q;
endmodule

// File: rtl/ghash_gf_mult.sv
module ghash_gf_mult
    import ghash_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [GH_W-1:0] x_in,
    input  logic [GH_W-1:0] h_in,
    output logic            busy,
    output logic            fin,
    output logic [GH_W-1:0] prod
);
    logic [GH_W-1:0]    z_q, v_q, x_q, z_n, v_n;
    logic [GH_CNTW-1:0] cnt_q;
    logic               busy_q, fin_q;

    always_comb begin
        z_n = x_q[GH_W-1] ? (z_q ^ v_q) : z_q;
        v_n = (v_q >> 1) ^ (v_q[0] ? GH_RED : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q    <= '0;
            v_q    <= '0;
            x_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                z_q    <= '0;
                v_q    <= h_in;
                x_q    <= x_in;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                z_q   <= z_n;
                v_q   <= v_n;
                x_q   <= x_q << 1;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == GH_CNTW'(GH_W - 1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign fin  = fin_q;
    assign prod = z_q;
endmodule

// File: rtl/ghash_key_unit.sv
module ghash_key_unit
    import ghash_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GH_LENW-1:0] len,
    input  logic [GH_W-1:0]    key_in,
    output logic               ok,
    output logic               err,
    output logic [GH_W-1:0]    h,
    output logic [GH_W-1:0]    hx
);
    logic [GH_W-1:0] h_q, hx_q;
    logic            err_q;

    assign ok = load && (len == GH_LENW'(GH_BYTES));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q   <= '0;
            hx_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= load && !ok;
            if (ok) begin
                h_q  <= key_in;
                hx_q <= derive_hx(key_in);
            end
        end
    end

    assign h   = h_q;
    assign hx  = hx_q;
    assign err = err_q;
endmodule

// File: rtl/ghash_stream.sv
module ghash_stream
    import ghash_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_load,
    input  logic [GH_LENW-1:0] key_len,
    input  logic [GH_W-1:0]    key_in,
    output logic               key_err,
    output logic [GH_W-1:0]    hkey_x,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    input  logic               in_last,
    input  logic               flush,
    output logic               in_ready,
    output logic [GH_W-1:0]    digest_out,
    output logic               done
);
    gh_state_e state_q, state_n;

    logic [GH_W-1:0]    acc_q, result_q, blk_view, mul_prod, h_key;
    logic [GH_IDXW-1:0] fill;
    logic final_q, key_ok, mul_busy, mul_fin;
    logic byte_push, flush_fire, full_now, tail_now, dispatch, final_req, empty_end;

    // Accept conditions (key load has priority over data; a byte over a flush).
    always_comb begin
        byte_push  = in_valid && in_ready && !key_load;
        flush_fire = flush && !in_valid && in_ready && !key_load;
        full_now   = byte_push && (fill == GH_IDXW'(GH_BYTES - 1));
        tail_now   = (byte_push && in_last) || (flush_fire && fill != '0);
        dispatch   = full_now || tail_now;
        final_req  = (byte_push && in_last) || flush_fire;
        empty_end  = flush_fire && (fill == '0);
    end

    ghash_key_unit u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (key_load && in_ready),
        .len    (key_len),
        .key_in (key_in),
        .ok     (key_ok),
        .err    (key_err),
        .h      (h_key),
        .hx     (hkey_x)
    );

    ghash_byte_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (byte_push),
        .byte_in  (in_byte),
        .clear    (dispatch || key_ok),
        .fill     (fill),
        .blk_view (blk_view)
    );

    ghash_gf_mult u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dispatch),
        .x_in  (acc_q ^ blk_view),
        .h_in  (h_key),
        .busy  (mul_busy),
        .fin   (mul_fin),
        .prod  (mul_prod)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (dispatch)       state_n = ST_MULT;
                     else if (empty_end) state_n = ST_DONE;
            ST_MULT: if (mul_fin)        state_n = final_q ? ST_DONE : ST_IDLE;
            ST_DONE:                     state_n = ST_IDLE;
            default:                     state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            result_q <= '0;
            final_q  <= 1'b0;
        end else begin
            if (dispatch) final_q <= final_req;
            if (key_ok || empty_end) acc_q <= '0;
            else if (mul_fin)        acc_q <= final_q ? '0 : mul_prod;
            if (mul_fin && final_q)  result_q <= mul_prod;
            else if (empty_end)      result_q <= acc_q;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = (state_q == ST_IDLE) && !mul_busy;
        done       = (state_q == ST_DONE);
        digest_out = result_q;
    end
endmodule

// File: rtl/ghash_stream_chk.sv
module ghash_stream_chk
    import ghash_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               key_load,
    input logic [GH_LENW-1:0] key_len,
    input logic               key_err,
    input logic [GH_W-1:0]    hkey_x,
    input logic               in_valid,
    input logic               in_last,
    input logic               in_ready,
    input logic [GH_W-1:0]    digest_out,
    input logic               done
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

    assert_digest_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(digest_out));

    assert_key_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && in_ready && key_len != GH_LENW'(GH_BYTES)) |=> (key_err && $stable(hkey_x)));

    assert_key_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && in_ready && key_len == GH_LENW'(GH_BYTES)) |=> !key_err);

    assert_busy_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !key_load) |=> !in_ready);
endmodule

bind ghash_stream ghash_stream_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_load   (key_load),
    .key_len    (key_len),
    .key_err    (key_err),
    .hkey_x     (hkey_x),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .digest_out (digest_out),
    .done       (done)
);

// File: tb/ghash_stream_test.sv
module ghash_stream_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [4:0]   key_len = 5'd0;
    logic [127:0] key_in = '0;
    logic         key_err;
    logic [127:0] hkey_x;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = 8'd0;
    logic         in_last = 1'b0;
    logic         flush = 1'b0;
    logic         in_ready;
    logic [127:0] digest_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0]   msg [0:63];
    logic [127:0] cur_h;

    always #10 clk = ~clk;

    ghash_stream uut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [127:0] ref_mul(input logic [127:0] x, input logic [127:0] h);
        logic [127:0] z = '0;
        logic [127:0] v = h;
        for (int i = 0; i < 128; i++) begin
            if (x[127 - i]) z = z ^ v;
            v = v[0] ? ((v >> 1) ^ {8'hE1, 120'd0}) : (v >> 1);
        end
        return z;
    endfunction

    function automatic logic [127:0] ref_hx(input logic [127:0] h);
        logic [127:0] r = {h[126:0], h[127]};
        if (h[127]) r[127:120] = r[127:120] ^ 8'hC2;
        return r;
    endfunction

    function automatic logic [127:0] ref_digest(input int len, input logic [127:0] h);
        logic [127:0] d = '0;
        logic [127:0] blk = '0;
        int k = 0;
        for (int i = 0; i < len; i++) begin
            blk[127 - 8*k -: 8] = msg[i];
            k++;
            if (k == 16) begin
                d = ref_mul(d ^ blk, h);
                blk = '0;
                k = 0;
            end
        end
        if (k != 0) d = ref_mul(d ^ blk, h);
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_ready(input bit garbage);
        while (!in_ready) begin
            if (garbage) begin
                in_valid = 1'b1;
                in_byte  = 8'($urandom);
                in_last  = 1'($urandom);
            end
            @(negedge clk);
        end
    endtask

    task automatic load_key(input logic [127:0] k, input logic [4:0] l);
        wait_ready(1'b0);
        key_load = 1'b1; key_len = l; key_in = k;
        @(negedge clk);
        key_load = 1'b0;
        if (l == 5'd16) cur_h = k;
    endtask

    // Sends msg[0:len-1], ends with in_last or flush, returns the digest seen at done.
    task automatic send_msg(input int len, input bit end_flush, input bit garbage,
                            input bit finish, output logic [127:0] dig);
        for (int i = 0; i < len; i++) begin
            wait_ready(garbage);
            in_valid = 1'b1;
            in_byte  = msg[i];
            in_last  = finish && !end_flush && (i == len - 1);
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
        end
        dig = '0;
        if (!finish) return;
        if (len == 0 || end_flush) begin
            wait_ready(garbage);
            in_valid = 1'b0; in_last = 1'b0;
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
        end
        while (!done) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        dig = digest_out;
        @(negedge clk);
        check(!done, "R8 done width", 128'(done), 128'd0);
    endtask

    task automatic run_and_check(input int len, input bit end_flush, input bit garbage, input string req);
        logic [127:0] d, e;
        e = ref_digest(len, cur_h);
        send_msg(len, end_flush, garbage, 1'b1, d);
        check(d === e, req, d, e);
    endtask

    initial begin
        logic [127:0] hold, d;
        void'($urandom(32'h5EED_0042));
        cur_h = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(digest_out === '0, "R1 digest", digest_out, '0);
        check(done === 1'b0, "R1 done", 128'(done), 128'd0);
        check(in_ready === 1'b1, "R1 ready", 128'(in_ready), 128'd1);

        // R2: accepted keys, top bit clear then set
        load_key(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 5'd16);
        check(hkey_x === ref_hx(cur_h), "R2 hx top0", hkey_x, ref_hx(cur_h));
        check(key_err === 1'b0, "R2 err", 128'(key_err), 128'd0);
        load_key(128'hC3A1_5B00_0000_0001_8000_0000_0000_00FF, 5'd16);
        check(hkey_x === ref_hx(cur_h), "R2 hx top1", hkey_x, ref_hx(cur_h));

        // R3: rejected key lengths
        hold = hkey_x;
        load_key(128'h1111_2222_3333_4444_5555_6666_7777_8888, 5'd15);
        check(key_err === 1'b1, "R3 err", 128'(key_err), 128'd1);
        check(hkey_x === hold, "R3 hx kept", hkey_x, hold);
        load_key(128'h9999_2222_3333_4444_5555_6666_7777_8888, 5'd0);
        check(hkey_x === hold, "R3 hx kept len0", hkey_x, hold);
        @(negedge clk);
        check(key_err === 1'b0, "R3 err pulse", 128'(key_err), 128'd0);

        // R4: single byte 0x80 gives H
        msg[0] = 8'h80;
        send_msg(1, 1'b0, 1'b0, 1'b1, d);
        check(d === cur_h, "R4 lane order", d, cur_h);

        // R7: empty message
        send_msg(0, 1'b1, 1'b0, 1'b1, d);
        check(d === '0, "R7 empty", d, '0);

        // R5/R7: exact blocks via last and via flush
        for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
        run_and_check(16, 1'b0, 1'b0, "R5 one block");
        run_and_check(16, 1'b1, 1'b0, "R7 block then flush");
        run_and_check(32, 1'b1, 1'b0, "R7 two blocks then flush");
        // R6: partial tails
        run_and_check(5, 1'b0, 1'b0, "R6 tail last");
        run_and_check(5, 1'b1, 1'b0, "R6 tail flush");
        run_and_check(31, 1'b0, 1'b0, "R6 block plus tail");
        // R9: garbage during multiply
        run_and_check(40, 1'b0, 1'b1, "R9 garbage ignored");
        run_and_check(17, 1'b1, 1'b1, "R9 garbage flush end");

        // R10: key load drops buffered bytes and digest
        send_msg(20, 1'b0, 1'b0, 1'b0, d);
        load_key(128'h5A5A_0F0F_F0F0_A5A5_1234_5678_9ABC_DEF0, 5'd16);
        run_and_check(7, 1'b0, 1'b0, "R10 fresh after key");

        // Random messages (R5, R6, R7, R8, R9)
        for (int m = 0; m < 24; m++) begin
            int len = $urandom_range(0, 48);
            for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
            if (m % 8 == 7) load_key({$urandom, $urandom, $urandom, $urandom}, 5'd16);
            run_and_check(len, (len == 0) ? 1'b1 : 1'($urandom), 1'($urandom), "R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule